// File: doc/BRIEF.md
# Display Power-Rail Start-Up Sequencer

This block is the digital controller for a four-rail display supply: a boost rail, a logic rail, a negative gate rail and a positive gate rail. It produces no analog waveforms. It decides when each rail enable is driven, when the active-low input-protection switch enable and the active-low delayed-boost switch enable are asserted, and when the supply set has reached normal operation. Timing comes from an internal up/down counter that rises and falls repeatedly. Each rise has a fast segment and then a slow segment. All sequence steps are tied to the peaks and valleys of this counter, so every delay scales from the same few parameters.

Faults are checked at fixed points of the sequence. During normal operation they are also checked continuously. Any fault latches the block into a shut-down state. Only a low level on the enable input or on the supply-good input clears that state. All asynchronous inputs pass through two-flop synchronisers. A strap input selects an alternate variant. In that variant the reference and the logic rail follow supply-good directly, and the reference stays on through a fault.

Top module: `psu_seq_ctrl`

## Requirements
- R1: While the synchronised enable or supply-good is low, every rail enable, ready and fault are low, and both active-low enables are high. The ramp starts only once both are high, whichever rises last, and the first ramp begins on the third clock edge after that input changes.
- R2: Each ramp rises for RAMP_KNEE steps of FAST_DIV cycles, then RAMP_TOP-RAMP_KNEE steps of SLOW_DIV cycles, and falls for RAMP_TOP steps of FAST_DIV cycles. Peak k is registered RISE cycles after the start of ramp k, and ramp k+1 starts one full period after ramp k starts.
- R3: A timing-node fault or a low reference-good, seen on the peak or valley cycle of ramp 1 or ramp 2, latches the fault state.
- R4: From the start of ramp 2 onward, a low reference-good or a high over-temperature flag latches the fault state three cycles after the input changes.
- R5: The active-low protection enable goes low at the peak of ramp 2.
- R6: The boost and logic rail enables go high at the end of ramp 2, which is the start of ramp 3.
- R7: The negative rail enable goes high at the peak of ramp 4, and the active-low delayed-boost enable goes low at the peak of ramp 5.
- R8: The positive rail enable goes high at the start of ramp 6, and ready goes high at the end of ramp 6.
- R9: In normal operation, an undervoltage flag (bit 0 boost, 1 logic, 2 negative, 3 positive) that stays high for UV_TIMEOUT synchronised cycles latches the fault state, and a shorter pulse does not. Before normal operation the flags have no effect.
- R10: In the fault state, fault is high, all four rail enables are low and both active-low enables are high. The state holds until enable or supply-good goes low, and it clears three cycles after that change.
- R11: With the variant strap high, the reference and logic enables go high two cycles after supply-good rises, regardless of enable. In the fault state the reference stays on and the logic enable is low.
- R12: With the variant strap low, the reference enable goes high at the start of ramp 1 and drops with all other outputs on a fault or shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Block enable (asynchronous) |
| supply_ok_i | input | 1 | Input supply above its good threshold (asynchronous) |
| ref_ok_i | input | 1 | Reference good (asynchronous) |
| over_temp_i | input | 1 | Die over-temperature flag (asynchronous) |
| tnode_fault_i | input | 1 | Fault on the timing node (asynchronous) |
| uv_i | input | 4 | Undervoltage flags: 0 boost, 1 logic, 2 negative, 3 positive |
| alt_variant_i | input | 1 | Static strap selecting the alternate variant |
| ref_on_o | output | 1 | Reference enable |
| boost_on_o | output | 1 | Boost rail enable |
| logic_on_o | output | 1 | Logic rail enable |
| neg_on_o | output | 1 | Negative gate rail enable |
| pos_on_o | output | 1 | Positive gate rail enable |
| prot_en_n_o | output | 1 | Active-low input-protection switch enable |
| dly_boost_en_n_o | output | 1 | Active-low delayed-boost switch enable |
| ready_o | output | 1 | Sequence complete, normal operation |
| fault_o | output | 1 | Fault latched |

## Verification
The bench builds the block with a ramp of height 4 and a knee at 2, with step dividers of 2 and 3 and an undervoltage timeout of 5. This gives a rise of 10 cycles and a period of 18 cycles, so a full six-ramp start-up takes just over a hundred cycles. Every sequence edge can therefore be measured to the exact cycle and compared with values computed from the period formula. The short timeout puts both sides of the persistence boundary within reach: a pulse one cycle too short and a pulse of exactly the timeout. It also allows the fault windows in ramp 1, in ramp 2 and in normal operation to be exercised in a few hundred cycles each.

// File: rtl/psu_seq_pkg.sv
package psu_seq_pkg;
  typedef enum logic [1:0] {PH_OFF, PH_RAMP, PH_RUN, PH_FAULT} phase_e;

  localparam int RAIL_N   = 4;
  localparam int RL_BOOST = 0;
  localparam int RL_LOGIC = 1;
  localparam int RL_NEG   = 2;
  localparam int RL_POS   = 3;

  typedef struct packed {
    logic              ref_on;
    logic [RAIL_N-1:0] rail;
    logic              prot_n;
    logic              dly_n;
  } outs_t;

  localparam outs_t OUTS_OFF = '{ref_on: 1'b0, rail: '0, prot_n: 1'b1, dly_n: 1'b1};
endpackage

// File: rtl/psu_seq_sync.sv
module psu_seq_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end
endmodule

// File: rtl/psu_seq_ramp.sv
module psu_seq_ramp #(
  parameter int CNT_W    = 8,
  parameter int TOP      = 200,
  parameter int KNEE     = 40,
  parameter int FAST_DIV = 50,
  parameter int SLOW_DIV = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic peak_o,
  output logic valley_o
);
  localparam int DIV_MAX = (FAST_DIV > SLOW_DIV) ? FAST_DIV : SLOW_DIV;
  localparam int PRE_W   = $clog2(DIV_MAX + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PRE_W-1:0] pre_q, pre_d, lim_m1;
  logic             up_q, up_d, step;

  always_comb begin
    lim_m1   = (up_q && cnt_q >= CNT_W'(KNEE)) ? PRE_W'(SLOW_DIV - 1) : PRE_W'(FAST_DIV - 1);
    step     = run_i && (pre_q == lim_m1);
    peak_o   = step && up_q && (cnt_q == CNT_W'(TOP - 1));
    valley_o = step && !up_q && (cnt_q == CNT_W'(1));
    cnt_d    = cnt_q;
    pre_d    = pre_q;
    up_d     = up_q;
    if (!run_i) begin
      cnt_d = '0;
      pre_d = '0;
      up_d  = 1'b1;
    end else if (step) begin
      pre_d = '0;
      if (up_q) begin
        cnt_d = cnt_q + 1'b1;
        if (peak_o) up_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
        if (valley_o) up_d = 1'b1;
      end
    end else begin
      pre_d = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pre_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      pre_q <= pre_d;
      up_q  <= up_d;
    end
  end
endmodule

// File: rtl/psu_seq_uvwatch.sv
module psu_seq_uvwatch #(
  parameter int N       = 4,
  parameter int TIMEOUT = 100000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] arm_i,
  input  logic [N-1:0] uv_i,
  output logic         trip_o
);
  localparam int TW = $clog2(TIMEOUT + 1);

  logic [N-1:0] hit;

  for (genvar i = 0; i < N; i++) begin : g_rail
    logic [TW-1:0] cnt_q, cnt_d;
    always_comb begin
      if (!(arm_i[i] && uv_i[i]))        cnt_d = '0;
      else if (cnt_q == TW'(TIMEOUT))    cnt_d = cnt_q;
      else                               cnt_d = cnt_q + 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
    end
    assign hit[i] = (cnt_q == TW'(TIMEOUT));
  end

  assign trip_o = |hit;
endmodule

// File: rtl/psu_seq_ctrl.sv
module psu_seq_ctrl
  import psu_seq_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int RAMP_TOP   = 200,
  parameter int RAMP_KNEE  = 40,
  parameter int FAST_DIV   = 50,
  parameter int SLOW_DIV   = 400,
  parameter int UV_TIMEOUT = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              supply_ok_i,
  input  logic              ref_ok_i,
  input  logic              over_temp_i,
  input  logic              tnode_fault_i,
  input  logic [RAIL_N-1:0] uv_i,
  input  logic              alt_variant_i,
  output logic              ref_on_o,
  output logic              boost_on_o,
  output logic              logic_on_o,
  output logic              neg_on_o,
  output logic              pos_on_o,
  output logic              prot_en_n_o,
  output logic              dly_boost_en_n_o,
  output logic              ready_o,
  output logic              fault_o
);
  localparam int SYNC_W   = 5 + RAIL_N;
  localparam int LAST_RMP = 6;

  logic [SYNC_W-1:0] sync_q;
  logic              en_s, sup_s, ref_s, hot_s, tf_s;
  logic [RAIL_N-1:0] uv_s;

  psu_seq_sync #(.W(SYNC_W)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({uv_i, tnode_fault_i, over_temp_i, ref_ok_i, supply_ok_i, en_i}),
    .q_o(sync_q)
  );
  assign {uv_s, tf_s, hot_s, ref_s, sup_s, en_s} = sync_q;

  phase_e     phase_q, phase_d;
  logic [2:0] idx_q, idx_d;
  outs_t      outs_q, outs_d;
  logic       peak, valley, uv_trip, fault_now;

  psu_seq_ramp #(
    .CNT_W(CNT_W), .TOP(RAMP_TOP), .KNEE(RAMP_KNEE),
    .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)
  ) u_ramp (
    .clk(clk), .rst_n(rst_n), .run_i(phase_q == PH_RAMP),
    .peak_o(peak), .valley_o(valley)
  );

  psu_seq_uvwatch #(.N(RAIL_N), .TIMEOUT(UV_TIMEOUT)) u_uv (
    .clk(clk), .rst_n(rst_n),
    .arm_i({RAIL_N{phase_q == PH_RUN}}), .uv_i(uv_s), .trip_o(uv_trip)
  );

  // Fault sources: edge checks in ramps 1-2, continuous checks from ramp 2 on.
  always_comb begin
    fault_now = 1'b0;
    if (phase_q == PH_RAMP) begin
      if ((peak || valley) && idx_q <= 3'd2 && (tf_s || !ref_s)) fault_now = 1'b1;
      if (idx_q >= 3'd2 && (hot_s || !ref_s))                    fault_now = 1'b1;
    end
    if (phase_q == PH_RUN && (hot_s || !ref_s || uv_trip))       fault_now = 1'b1;
  end

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    outs_d  = outs_q;
    if (!en_s || !sup_s) begin
      phase_d = PH_OFF;
      idx_d   = '0;
      outs_d  = OUTS_OFF;
    end else begin
      unique case (phase_q)
        PH_OFF: begin
          phase_d       = PH_RAMP;
          idx_d         = 3'd1;
          outs_d.ref_on = 1'b1;
        end
        PH_RAMP: begin
          if (fault_now) begin
            phase_d = PH_FAULT;
            outs_d  = OUTS_OFF;
          end else begin
            if (peak) begin
              if (idx_q == 3'd2) outs_d.prot_n        = 1'b0;
              if (idx_q == 3'd4) outs_d.rail[RL_NEG]  = 1'b1;
              if (idx_q == 3'd5) outs_d.dly_n         = 1'b0;
            end
            if (valley) begin
              if (idx_q == 3'(LAST_RMP)) phase_d = PH_RUN;
              else                       idx_d   = idx_q + 1'b1;
              if (idx_q == 3'd2) begin
                outs_d.rail[RL_BOOST] = 1'b1;
                outs_d.rail[RL_LOGIC] = 1'b1;
              end
              if (idx_q == 3'(LAST_RMP - 1)) outs_d.rail[RL_POS] = 1'b1;
            end
          end
        end
        PH_RUN: begin
          if (fault_now) begin
            phase_d = PH_FAULT;
            outs_d  = OUTS_OFF;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_OFF;
      idx_q   <= '0;
      outs_q  <= OUTS_OFF;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
      outs_q  <= outs_d;
    end
  end

  assign ref_on_o         = alt_variant_i ? sup_s : outs_q.ref_on;
  assign logic_on_o       = alt_variant_i ? (sup_s && phase_q != PH_FAULT) : outs_q.rail[RL_LOGIC];
  assign boost_on_o       = outs_q.rail[RL_BOOST];
  assign neg_on_o         = outs_q.rail[RL_NEG];
  assign pos_on_o         = outs_q.rail[RL_POS];
  assign prot_en_n_o      = outs_q.prot_n;
  assign dly_boost_en_n_o = outs_q.dly_n;
  assign ready_o          = (phase_q == PH_RUN);
  assign fault_o          = (phase_q == PH_FAULT);
endmodule

// File: rtl/psu_seq_ctrl_chk.sv
module psu_seq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_i,
  input logic       supply_ok_i,
  input logic [3:0] uv_i,
  input logic       boost_on_o,
  input logic       neg_on_o,
  input logic       pos_on_o,
  input logic       prot_en_n_o,
  input logic       dly_boost_en_n_o,
  input logic       ready_o,
  input logic       fault_o
);
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 1'b1;
  end

  // R10
  fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (!boost_on_o && !neg_on_o && !pos_on_o && prot_en_n_o && dly_boost_en_n_o));

  // R10
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3 && fault_o && en_i && $past(en_i) && supply_ok_i && $past(supply_ok_i))
      |=> fault_o);

  // R7
  neg_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    neg_on_o |-> (!prot_en_n_o && boost_on_o));

  // R8
  pos_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos_on_o |-> (neg_on_o && !dly_boost_en_n_o));

  // R8
  ready_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (pos_on_o && !fault_o));

  // R1
  idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3 && !en_i && !$past(en_i) && !$past(en_i, 2))
      |=> (!boost_on_o && !neg_on_o && !pos_on_o && prot_en_n_o && !ready_o && !fault_o));
endmodule

bind psu_seq_ctrl psu_seq_ctrl_chk u_chk (.*);

// File: tb/psu_seq_ctrl_bench.sv
module psu_seq_ctrl_bench;
  localparam int TOP   = 4;
  localparam int KNEE  = 2;
  localparam int FDIV  = 2;
  localparam int SDIV  = 3;
  localparam int UV_TO = 5;
  localparam int RISE  = KNEE * FDIV + (TOP - KNEE) * SDIV;
  localparam int PER   = RISE + TOP * FDIV;
  localparam int LAT   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, sup = 1'b0, refok = 1'b1, hot = 1'b0, tf = 1'b0, alt = 1'b0;
  logic [3:0] uv = 4'b0;
  logic ref_on, boost_on, logic_on, neg_on, pos_on, prot_n, dly_n, ready, fault;

  int cyc = 0;
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  psu_seq_ctrl #(
    .CNT_W(3), .RAMP_TOP(TOP), .RAMP_KNEE(KNEE),
    .FAST_DIV(FDIV), .SLOW_DIV(SDIV), .UV_TIMEOUT(UV_TO)
  ) u_psu_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .en_i(en), .supply_ok_i(sup), .ref_ok_i(refok),
    .over_temp_i(hot), .tnode_fault_i(tf), .uv_i(uv), .alt_variant_i(alt),
    .ref_on_o(ref_on), .boost_on_o(boost_on), .logic_on_o(logic_on),
    .neg_on_o(neg_on), .pos_on_o(pos_on), .prot_en_n_o(prot_n),
    .dly_boost_en_n_o(dly_n), .ready_o(ready), .fault_o(fault)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic to_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int all_off();
    return int'(!boost_on && !neg_on && !pos_on && prot_n && dly_n && !ready);
  endfunction

  // Starts a sequence by raising enable or supply and times every output edge.
  task automatic run_seq(input bit by_supply, input bit altm, input int uv_release);
    int t0, e0;
    int t_ref = -1, t_boost = -1, t_logic = -1, t_neg = -1, t_pos = -1;
    int t_prot = -1, t_dly = -1, t_rdy = -1;
    bit saw_fault = 1'b0;
    @(negedge clk);
    t0 = cyc;
    if (by_supply) sup = 1'b1; else en = 1'b1;
    for (int i = 0; i < 130; i++) begin
      @(negedge clk);
      if (uv_release > 0 && cyc == t0 + uv_release) uv = 4'b0;
      if (ref_on   && t_ref   < 0) t_ref   = cyc;
      if (boost_on && t_boost < 0) t_boost = cyc;
      if (logic_on && t_logic < 0) t_logic = cyc;
      if (neg_on   && t_neg   < 0) t_neg   = cyc;
      if (pos_on   && t_pos   < 0) t_pos   = cyc;
      if (!prot_n  && t_prot  < 0) t_prot  = cyc;
      if (!dly_n   && t_dly   < 0) t_dly   = cyc;
      if (ready    && t_rdy   < 0) t_rdy   = cyc;
      if (fault) saw_fault = 1'b1;
    end
    e0 = t0 + LAT;
    if (!altm) begin
      check(t_ref == e0, "R12 ref at ramp 1 start", t_ref - t0, e0 - t0);
      check(t_logic == e0 + 2 * PER, "R6 logic at ramp 3 start", t_logic - t0, e0 + 2 * PER - t0);
    end
    check(t_prot == e0 + PER + RISE, "R5 protection at peak 2", t_prot - t0, e0 + PER + RISE - t0);
    check(t_boost == e0 + 2 * PER, "R6 boost at ramp 3 start", t_boost - t0, e0 + 2 * PER - t0);
    check(t_neg == e0 + 3 * PER + RISE, "R7 negative at peak 4", t_neg - t0, e0 + 3 * PER + RISE - t0);
    check(t_dly == e0 + 4 * PER + RISE, "R7 delayed boost at peak 5", t_dly - t0, e0 + 4 * PER + RISE - t0);
    check(t_pos == e0 + 5 * PER, "R8 positive at ramp 6 start", t_pos - t0, e0 + 5 * PER - t0);
    check(t_rdy == e0 + 6 * PER, "R8 ready at ramp 6 end / R2 period", t_rdy - t0, e0 + 6 * PER - t0);
    check(!saw_fault, "R9 no fault during sequence", int'(saw_fault), 0);
  endtask

  initial begin : watchdog
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    int d;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    check(all_off() == 1 && !ref_on && !fault, "R1 reset state", all_off(), 1);

    // R1: supply good, enable low
    sup = 1'b1;
    wait_n(60);
    check(all_off() == 1 && !ref_on && !fault, "R1 idle while enable low", all_off(), 1);

    // Normal start-up, variant strap low
    run_seq(1'b0, 1'b0, 0);

    // R4: over-temperature in normal operation
    @(negedge clk); d = cyc; hot = 1'b1;
    to_cyc(d + 2);
    check(!fault, "R4 hot not yet latched", int'(fault), 0);
    to_cyc(d + 3);
    check(fault, "R4 hot latches fault", int'(fault), 1);
    check(all_off() == 1 && !ref_on, "R10 outputs off in fault", all_off(), 1);
    hot = 1'b0;
    wait_n(40);
    check(fault, "R10 latch holds after cause clears", int'(fault), 1);

    // R10: enable low clears the latch
    @(negedge clk); d = cyc; en = 1'b0;
    to_cyc(d + 2);
    check(fault, "R10 latch before clear", int'(fault), 1);
    to_cyc(d + 3);
    check(!fault, "R10 enable low clears", int'(fault), 0);

    // R1: enable high while supply low, ramp waits for supply
    sup = 1'b0;
    wait_n(5);
    en = 1'b1;
    wait_n(60);
    check(all_off() == 1 && !ref_on && !fault, "R1 wait for supply", all_off(), 1);
    run_seq(1'b1, 1'b0, 0);

    // R9: undervoltage pulse one cycle shorter than timeout
    @(negedge clk); d = cyc; uv[2] = 1'b1;
    to_cyc(d + UV_TO - 1); uv[2] = 1'b0;
    wait_n(20);
    check(!fault && ready, "R9 short undervoltage ignored", int'(fault), 0);
    // R9: undervoltage held for the full timeout
    @(negedge clk); d = cyc; uv[2] = 1'b1;
    to_cyc(d + 2 + UV_TO);
    check(!fault, "R9 not tripped before timeout", int'(fault), 0);
    to_cyc(d + 3 + UV_TO);
    check(fault, "R9 tripped at timeout", int'(fault), 1);
    uv = 4'b0;

    // R10: supply drop clears the latch
    wait_n(5);
    @(negedge clk); d = cyc; sup = 1'b0;
    to_cyc(d + 3);
    check(!fault, "R10 supply drop clears", int'(fault), 0);

    // R3: timing-node fault at the first peak
    en = 1'b0; sup = 1'b1; tf = 1'b1;
    wait_n(6);
    @(negedge clk); d = cyc; en = 1'b1;
    to_cyc(d + LAT + RISE - 1);
    check(!fault && ref_on, "R3 running before first peak", int'(fault), 0);
    to_cyc(d + LAT + RISE);
    check(fault, "R3 timing fault at peak 1", int'(fault), 1);
    check(prot_n && !ref_on, "R3 protection and reference off", int'(prot_n), 1);
    tf = 1'b0; en = 1'b0;
    wait_n(6);

    // R4: reference loss during ramp 2
    @(negedge clk); d = cyc; en = 1'b1;
    to_cyc(d + LAT + PER + 3); refok = 1'b0;
    to_cyc(d + LAT + PER + 5);
    check(!fault, "R4 reference loss pending", int'(fault), 0);
    to_cyc(d + LAT + PER + 6);
    check(fault && prot_n, "R4 reference loss in ramp 2", int'(fault), 1);
    refok = 1'b1; en = 1'b0; sup = 1'b0;
    wait_n(6);

    // R11: alternate variant
    alt = 1'b1;
    wait_n(2);
    @(negedge clk); d = cyc; sup = 1'b1;
    to_cyc(d + 1);
    check(!ref_on && !logic_on, "R11 alt before sync", int'(ref_on), 0);
    to_cyc(d + 2);
    check(ref_on && logic_on && !boost_on, "R11 alt ref and logic follow supply", int'(ref_on && logic_on), 1);
    uv[0] = 1'b1;
    run_seq(1'b0, 1'b1, 100);
    @(negedge clk); d = cyc; hot = 1'b1;
    to_cyc(d + 3);
    check(fault && ref_on, "R11 alt reference stays on in fault", int'(ref_on), 1);
    check(!logic_on && !boost_on, "R11 alt logic off in fault", int'(logic_on), 0);
    hot = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule